// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block holds the software-visible state of one general-purpose I/O port, 32 bits wide by default. Software reaches it through a simple register bus with byte-lane enables. Through that bus it sets each pin as an input or an output, writes the output latch, and reads back either the latch or the live pin level. Each pad gets an output value and an output enable, and the enable is high only where the direction bit selects an output. Pin levels pass through a two-stage synchronizer before any read can see them.

A mask register fences off a group of bits. Whole-port value writes, set writes and clear writes leave masked bits alone, and value and latch reads return zero in those positions. Software can therefore update one group of pins with a single access and leave its neighbours untouched. The set register forces chosen outputs high and the clear register forces chosen outputs low, so any number of bits change in one write.

A request is accepted in every cycle where `bus_valid` is high, so the bus never stalls. A read returns its data on `bus_rdata` one cycle after the request, with `bus_rvalid` high for that cycle. `bus_rdata` then holds its value until the next read. Word addresses are byte offsets with bits [1:0] ignored. The map is 0x00 direction, 0x04 mask, 0x08 pin/value, 0x0C set and 0x10 clear.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the direction, mask and output latch registers are all zero, so `pad_oe` is all zero, `pad_out` is all zero and every register reads zero.
- R2: `pad_oe` bit i equals direction bit i (1 = output), and `pad_out` always presents the output latch.
- R3: A write changes only the bytes whose lane enable is set, where `bus_be[k]` covers bits 8k+7..8k. This holds for the direction, mask, value, set and clear registers.
- R4: A write of ones to 0x0C sets the corresponding unmasked latch bits to 1. Zero bits leave the latch unchanged.
- R5: A write of ones to 0x10 clears the corresponding unmasked latch bits to 0. Zero bits leave the latch unchanged.
- R6: Latch bits whose mask bit is 1 are unchanged by writes to 0x08, 0x0C and 0x10, and they read as zero from 0x08 and 0x0C.
- R7: A single write to 0x08 loads every enabled, unmasked latch bit from the write data.
- R8: Reads return the direction from 0x00, the mask from 0x04, the synchronized pin levels from 0x08, the output latch from 0x0C and zero from 0x10.
- R9: A pin level that has been stable at `pad_in` across two rising clock edges is returned by a read issued after them. A read issued after only one such edge still returns the previous level. Read data appears one cycle after the request, with `bus_rvalid` high only for that cycle.
- R10: Addresses above 0x10 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [1:0] ignored |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output latch toward the pads |
| pad_oe | output | 32 | Per-pin output enable |

## Verification
A wrong direction or latch bit shows at `pad_oe` or `pad_out` in the cycle after the write that caused it, with no read needed. A lane-decode fault or a mask leak shows as a corrupted neighbouring byte or group on those pads and in the next read of 0x00 or 0x0C. A synchronizer of the wrong depth returns a pin level one cycle early or late, which the bench catches by reading after exactly one edge and again after two. A wrong read mux shows in the cycle where `bus_rvalid` rises.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_VAL  = 3'd2,
    SEL_SET  = 3'd3,
    SEL_CLR  = 3'd4,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Word index (byte address >> 2) to register select.
  function automatic reg_sel_e decode_word(input logic [7:0] word_idx);
    reg_sel_e s;
    case (word_idx)
      8'd0:    s = SEL_DIR;
      8'd1:    s = SEL_MASK;
      8'd2:    s = SEL_VAL;
      8'd3:    s = SEL_SET;
      8'd4:    s = SEL_CLR;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] lane_bits,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] out_q
);

  logic [WIDTH-1:0] dir_d, mask_d, out_d;
  logic [WIDTH-1:0] open_bits;

  assign open_bits = lane_bits & ~mask_q;

  always_comb begin
    dir_d  = dir_q;
    mask_d = mask_q;
    out_d  = out_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_DIR:  dir_d  = (dir_q  & ~lane_bits) | (wr_data & lane_bits);
        SEL_MASK: mask_d = (mask_q & ~lane_bits) | (wr_data & lane_bits);
        SEL_VAL:  out_d  = (out_q  & ~open_bits) | (wr_data & open_bits);
        SEL_SET:  out_d  = out_q | (wr_data & open_bits);
        SEL_CLR:  out_d  = out_q & ~(wr_data & open_bits);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      dir_q  <= dir_d;
      mask_q <= mask_d;
      out_q  <= out_d;
    end
  end

  // R4: a set write never lowers a latch bit
  a_r4_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SET) |=> (($past(out_q) & ~out_q) == '0));

  // R5: a clear write never raises a latch bit
  a_r5_clear_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CLR) |=> ((~$past(out_q) & out_q) == '0));

  // R6: masked latch bits hold across value/set/clear writes
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_VAL || wr_sel == SEL_SET || wr_sel == SEL_CLR))
    |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

  // R3: disabled lanes of the direction register hold
  a_r3_dir_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(lane_bits)) == '0));

  // R10: unmapped writes change nothing
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(dir_q) && $stable(mask_q) && $stable(out_q)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  localparam int LANES = WIDTH / 8;

  logic [WIDTH-1:0] lane_bits;
  logic [WIDTH-1:0] dir_q, mask_q, out_q, pin_sync;
  logic [WIDTH-1:0] rd_mux;
  logic [7:0]       word_idx;
  reg_sel_e         sel;
  logic             rd_req, wr_req;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bits[8*k +: 8] = {8{bus_be[k]}};
  end

  always_comb begin
    word_idx = '0;
    word_idx[ADDR_W-3:0] = bus_addr[ADDR_W-1:2];
  end

  assign sel    = decode_word(word_idx);
  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;

  gpio_reg_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_req),
    .wr_sel    (sel),
    .wr_data   (bus_wdata),
    .lane_bits (lane_bits),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .out_q     (out_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (pin_sync)
  );

  always_comb begin
    case (sel)
      SEL_DIR:  rd_mux = dir_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_VAL:  rd_mux = pin_sync & ~mask_q;
      SEL_SET:  rd_mux = out_q & ~mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  // R9: exactly one response cycle per read request
  a_r9_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  a_r9_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);

  // R8: clear register reads zero
  a_r8_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == SEL_CLR) |=> (bus_rdata == '0));

  // R6: masked bits read zero from value and set
  a_r6_masked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (sel == SEL_VAL || sel == SEL_SET)) |=> ((bus_rdata & $past(mask_q)) == '0));

  // R10: unmapped reads return zero
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == SEL_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic        bus_rvalid;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_dir = '0, m_mask = '0, m_out = '0;
  logic [W-1:0] pat = 32'h1234_5678;
  logic [W-1:0] rd;

  always #10 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [W-1:0] lanes(input logic [3:0] be);
    logic [W-1:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  task automatic next_pat();
    pat = {pat[30:0], pat[31] ^ pat[21] ^ pat[1] ^ pat[0]};
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d, input logic [3:0] be);
    logic [W-1:0] lb, ob;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    lb = lanes(be);
    ob = lb & ~m_mask;
    case (a)
      5'h00: m_dir  = (m_dir  & ~lb) | (d & lb);
      5'h04: m_mask = (m_mask & ~lb) | (d & lb);
      5'h08: m_out  = (m_out  & ~ob) | (d & ob);
      5'h0C: m_out  = m_out | (d & ob);
      5'h10: m_out  = m_out & ~(d & ob);
      default: ;
    endcase
  endtask

  task automatic rdr(input logic [4:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL R9 rvalid actual=%b expected=1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    rdr(5'h00, rd); check({req, " dir"},  rd, m_dir);
    rdr(5'h04, rd); check({req, " mask"}, rd, m_mask);
    rdr(5'h0C, rd); check({req, " latch"}, rd, m_out & ~m_mask);
    rdr(5'h10, rd); check("R8 clear read", rd, '0);
    check("R2 pad_oe", pad_oe, m_dir);
    check("R2 pad_out", pad_out, m_out);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 pad_oe reset", pad_oe, '0);
    check("R1 pad_out reset", pad_out, '0);
    rst_n = 1'b1;
    check_all("R1");
    @(negedge clk);
    check("R9 rvalid idle", {31'd0, bus_rvalid}, '0);

    // R3: all lane patterns on direction and mask
    for (int be = 0; be < 16; be++) begin
      next_pat();
      wr(5'h00, pat, be[3:0]);
      rdr(5'h00, rd); check("R3 dir lanes", rd, m_dir);
      check("R2 pad_oe follows dir", pad_oe, m_dir);
    end
    for (int be = 0; be < 16; be++) begin
      next_pat();
      wr(5'h04, pat, be[3:0]);
      rdr(5'h04, rd); check("R3 mask lanes", rd, m_mask);
    end

    // R7/R6: whole-port writes under varied masks and lanes
    for (int i = 0; i < 24; i++) begin
      next_pat(); wr(5'h04, (i < 4) ? '0 : pat, 4'hF);
      next_pat(); wr(5'h08, pat, (i % 3 == 0) ? 4'hF : pat[3:0]);
      rdr(5'h0C, rd); check("R7 value write", rd, m_out & ~m_mask);
      check("R6 masked hold pad_out", pad_out, m_out);
    end

    // R4/R5: set and clear sweeps
    for (int i = 0; i < 24; i++) begin
      next_pat(); wr(5'h04, (i % 4 == 0) ? '0 : pat & 32'h0F0F_33CC, 4'hF);
      next_pat(); wr(5'h0C, pat, pat[7:4]);
      check("R4 set", pad_out, m_out);
      next_pat(); wr(5'h10, pat, pat[11:8]);
      check("R5 clear", pad_out, m_out);
    end
    wr(5'h04, '0, 4'hF);
    wr(5'h0C, 32'hFFFF_FFFF, 4'hF);
    check("R4 set all", pad_out, 32'hFFFF_FFFF);
    wr(5'h10, 32'h0000_FFFF, 4'hF);
    check("R5 clear low half", pad_out, 32'hFFFF_0000);

    // R8: pin reads with masks
    for (int i = 0; i < 16; i++) begin
      next_pat(); wr(5'h04, (i < 4) ? '0 : ~pat, 4'hF);
      next_pat();
      @(negedge clk); pad_in = pat;
      @(posedge clk); @(posedge clk);
      rdr(5'h08, rd); check("R8 pin read", rd, pat & ~m_mask);
    end

    // R9: synchronizer depth
    wr(5'h04, '0, 4'hF);
    @(negedge clk); pad_in = 32'hA5A5_0F0F;
    repeat (3) @(posedge clk);
    @(negedge clk); pad_in = 32'h5A5A_F0F0;
    @(posedge clk);
    rdr(5'h08, rd); check("R9 one edge old level", rd, 32'hA5A5_0F0F);
    @(negedge clk); pad_in = 32'h1111_2222;
    @(posedge clk); @(posedge clk);
    rdr(5'h08, rd); check("R9 two edges new level", rd, 32'h1111_2222);

    // R10: unmapped addresses
    wr(5'h14, 32'hDEAD_BEEF, 4'hF);
    wr(5'h1C, 32'hFFFF_FFFF, 4'hF);
    rdr(5'h18, rd); check("R10 unmapped read", rd, '0);
    check_all("R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule